// File: doc/BRIEF.md
# Contact image sensor timing generator

This block produces the digital drive for a scan module built from several linear image sensor dies chained end to end. Working from a fast system clock, it divides down a shift clock for the dies' readout shift registers. It also issues a start pulse that begins each line and a reset-switch enable. That enable grounds the external integrating capacitor during the clock-high phase. The fourth output is a one-cycle ADC sample strobe for every pixel. The returned end-of-scan signal from the last die is checked against the expected pixel count, and a line-done pulse marks the end of each readout.

The divider, the duty mode, the requested line period (in shift-clock periods), the die count and the ADC settling delay are plain control inputs. They are captured when `enable` rises and held for the whole run, so software may rewrite them at any time. A new setting takes effect on the next enable. Every die carries 96 pixels, so a line must last at least dies × 96 shift periods. A shorter request is stretched to that length and flagged. The block has no streaming data path, so every pin is a plain level or pulse with no handshake.

Top module: `cis_timing_gen`

## Requirements
- R1: While `rst_n` is low, or while `enable` is low, all outputs are 0 (sticky flags are cleared by reset only); one cycle after `enable` falls, the four drive outputs and `line_done` are 0.
- R2: The shift-clock period is max(`div_cfg`, 4) system clocks, and a divider below 4 is raised to 4. The first system cycle of each period has `shift_clk` high.
- R3: `shift_clk` is high for the first floor(D/4) system cycles of each period when `duty_half`=0, and for the first floor(D/2) when `duty_half`=1, where D is the effective divider. `cap_reset` is high in exactly the same cycles.
- R4: `start_pulse` is high for the whole of shift period 0 of every line. It rises together with `shift_clk`, so exactly one falling edge of `shift_clk` lies inside it.
- R5: A line lasts L = max(`line_cfg`, N) shift periods, with N = dies × 96. A `die_cfg` of 0 counts as 1 die, and a value above the die limit counts as the limit.
- R6: `short_line` becomes 1 when a run starts with `line_cfg` < N, and stays 1 until reset.
- R7: `adc_strobe` is a one-cycle pulse in system cycle min(h + `settle_cfg`, D−1) of each shift period, where h is the high time. It occurs only in pixel periods 0..N−1 of a line.
- R8: `line_done` is a one-cycle pulse in the first system cycle of the shift period that follows pixel period N−1.
- R9: If `eos_in` is not seen high in any system cycle of pixel period N−1, then `eos_error` becomes 1 in the same cycle as that `line_done`. It stays 1 until reset.
- R10: Configuration inputs are captured when `enable` rises. Changes made while running have no effect on any output until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; a rise captures the configuration and starts line 0 |
| div_cfg | input | 16 | System clocks per shift-clock period (minimum 4) |
| duty_half | input | 1 | 0: 25 % high time, 1: 50 % high time |
| line_cfg | input | 16 | Requested line period in shift-clock periods |
| die_cfg | input | 5 | Number of cascaded dies |
| settle_cfg | input | 8 | ADC settling delay in system clocks after the shift-clock falling edge |
| eos_in | input | 1 | End-of-scan returned by the last die, synchronous to `clk` |
| shift_clk | output | 1 | Pixel shift clock to the dies |
| start_pulse | output | 1 | Line start pulse |
| cap_reset | output | 1 | Enable for the switch that grounds the video line |
| adc_strobe | output | 1 | One-cycle ADC sample command per pixel |
| line_done | output | 1 | One-cycle end-of-readout pulse |
| short_line | output | 1 | Sticky: line request was below the minimum |
| eos_error | output | 1 | Sticky: end-of-scan missing in the expected pixel period |

## Verification
The embedded properties assume that `eos_in` is already synchronous to `clk` and that the die limit keeps N within the 16-bit line counter. They also rely on the effective divider being at least 4, so `line_done` can never fire on two adjacent cycles. The bench drives every input only on the falling clock edge and keeps `eos_in` a clean level aligned to whole pixel periods. Mid-run configuration writes use legal values, so only the capture rule is under test and not any out-of-range arithmetic.

// File: rtl/cis_tg_pkg.sv
package cis_tg_pkg;
  parameter int DIV_W  = 16;
  parameter int LINE_W = 16;
  parameter int DIE_W  = 5;
  parameter int SET_W  = 8;
  parameter int MIN_DIV = 4;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [DIV_W-1:0]  hi;
    logic [DIV_W-1:0]  pos;
    logic [LINE_W-1:0] npix;
    logic [LINE_W-1:0] line;
    logic              short_req;
  } tg_cfg_t;
endpackage

// File: rtl/cis_tg_cfg.sv
// Clamps raw configuration into an effective, self-consistent set.
module cis_tg_cfg
  import cis_tg_pkg::*;
#(
  parameter int MAX_DIES    = 16,
  parameter int PIX_PER_DIE = 96
) (
  input  logic [DIV_W-1:0]  div_raw,
  input  logic              half_raw,
  input  logic [LINE_W-1:0] line_raw,
  input  logic [DIE_W-1:0]  die_raw,
  input  logic [SET_W-1:0]  settle_raw,
  output tg_cfg_t           cfg
);
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] ONE_D     = DIV_W'(1);
  localparam logic [DIE_W-1:0] DIE_MAX   = DIE_W'(MAX_DIES);
  localparam logic [DIE_W-1:0] DIE_ONE   = DIE_W'(1);

  logic [DIV_W-1:0]  div_e;
  logic [DIV_W-1:0]  hi_e;
  logic [DIV_W:0]    pos_sum;
  logic [DIE_W-1:0]  dies_e;
  logic [LINE_W-1:0] npix_e;

  always_comb begin
    div_e   = (div_raw < DIV_FLOOR) ? DIV_FLOOR : div_raw;
    hi_e    = half_raw ? (div_e >> 1) : (div_e >> 2);
    pos_sum = {1'b0, hi_e} + (DIV_W+1)'(settle_raw);
    if (die_raw == '0)          dies_e = DIE_ONE;
    else if (die_raw > DIE_MAX) dies_e = DIE_MAX;
    else                        dies_e = die_raw;
    npix_e  = LINE_W'(dies_e) * LINE_W'(PIX_PER_DIE);

    cfg.div       = div_e;
    cfg.hi        = hi_e;
    cfg.pos       = (pos_sum > {1'b0, div_e - ONE_D}) ? (div_e - ONE_D) : pos_sum[DIV_W-1:0];
    cfg.npix      = npix_e;
    cfg.short_req = (line_raw < npix_e);
    cfg.line      = cfg.short_req ? npix_e : line_raw;
  end
endmodule

// File: rtl/cis_tg_counter.sv
// System-cycle phase counter within a shift period, and pixel counter within a line.
module cis_tg_counter
  import cis_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div,
  input  logic [LINE_W-1:0] line,
  output logic              run_q,
  output logic [DIV_W-1:0]  ph_q,
  output logic [LINE_W-1:0] pix_q,
  output logic              run_n,
  output logic [DIV_W-1:0]  ph_n,
  output logic [LINE_W-1:0] pix_n,
  output logic              start,
  output logic              wrap
);
  localparam logic [DIV_W-1:0]  ONE_D = DIV_W'(1);
  localparam logic [LINE_W-1:0] ONE_L = LINE_W'(1);

  always_comb begin
    start = enable && !run_q;
    wrap  = run_q && (ph_q == div - ONE_D);
    if (!enable) begin
      run_n = 1'b0;
      ph_n  = '0;
      pix_n = '0;
    end else if (start) begin
      run_n = 1'b1;
      ph_n  = '0;
      pix_n = '0;
    end else begin
      run_n = 1'b1;
      ph_n  = wrap ? '0 : ph_q + ONE_D;
      if (wrap) pix_n = (pix_q == line - ONE_L) ? '0 : pix_q + ONE_L;
      else      pix_n = pix_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= '0;
      pix_q <= '0;
    end else begin
      run_q <= run_n;
      ph_q  <= ph_n;
      pix_q <= pix_n;
    end
  end

  // R2
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ph_q < div));
endmodule

// File: rtl/cis_tg_decode.sv
// Registered output decode plus end-of-scan supervision.
module cis_tg_decode
  import cis_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_n,
  input  logic [DIV_W-1:0]  ph_n,
  input  logic [LINE_W-1:0] pix_n,
  input  logic [DIV_W-1:0]  hi_use,
  input  logic [DIV_W-1:0]  pos_use,
  input  logic [LINE_W-1:0] npix_use,
  input  logic              run_q,
  input  logic              wrap,
  input  logic [LINE_W-1:0] pix_q,
  input  logic [LINE_W-1:0] npix_q,
  input  logic              eos_in,
  output logic              shift_clk,
  output logic              cap_reset,
  output logic              start_pulse,
  output logic              adc_strobe,
  output logic              line_done,
  output logic              eos_error
);
  localparam logic [LINE_W-1:0] ONE_L = LINE_W'(1);

  logic last_pix;
  logic end_ev;
  logic eos_seen;

  always_comb begin
    last_pix = run_q && (pix_q == npix_q - ONE_L);
    end_ev   = run_n && wrap && last_pix;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_clk   <= 1'b0;
      cap_reset   <= 1'b0;
      start_pulse <= 1'b0;
      adc_strobe  <= 1'b0;
      line_done   <= 1'b0;
      eos_error   <= 1'b0;
      eos_seen    <= 1'b0;
    end else begin
      shift_clk   <= run_n && (ph_n < hi_use);
      cap_reset   <= run_n && (ph_n < hi_use);
      start_pulse <= run_n && (pix_n == '0);
      adc_strobe  <= run_n && (ph_n == pos_use) && (pix_n < npix_use);
      line_done   <= end_ev;
      if (end_ev && !(eos_seen || eos_in)) eos_error <= 1'b1;
      if (run_n && last_pix && !wrap) eos_seen <= eos_seen || eos_in;
      else                            eos_seen <= 1'b0;
    end
  end

  // R4
  st_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pulse) |-> shift_clk);
  // R7
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |-> !shift_clk);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  // R9
  eos_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos_error |=> eos_error);
endmodule

// File: rtl/cis_timing_gen.sv
module cis_timing_gen
  import cis_tg_pkg::*;
#(
  parameter int MAX_DIES    = 16,
  parameter int PIX_PER_DIE = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [15:0]       div_cfg,
  input  logic              duty_half,
  input  logic [15:0]       line_cfg,
  input  logic [4:0]        die_cfg,
  input  logic [7:0]        settle_cfg,
  input  logic              eos_in,
  output logic              shift_clk,
  output logic              start_pulse,
  output logic              cap_reset,
  output logic              adc_strobe,
  output logic              line_done,
  output logic              short_line,
  output logic              eos_error
);
  tg_cfg_t cfg_raw;
  tg_cfg_t cfg_q;
  tg_cfg_t cfg_use;

  logic              run_q, run_n, start, wrap;
  logic [DIV_W-1:0]  ph_q, ph_n;
  logic [LINE_W-1:0] pix_q, pix_n;

  cis_tg_cfg #(.MAX_DIES(MAX_DIES), .PIX_PER_DIE(PIX_PER_DIE)) u_cfg (
    .div_raw   (DIV_W'(div_cfg)),
    .half_raw  (duty_half),
    .line_raw  (LINE_W'(line_cfg)),
    .die_raw   (DIE_W'(die_cfg)),
    .settle_raw(SET_W'(settle_cfg)),
    .cfg       (cfg_raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      short_line <= 1'b0;
    end else if (start) begin
      cfg_q <= cfg_raw;
      if (cfg_raw.short_req) short_line <= 1'b1;
    end
  end

  always_comb cfg_use = start ? cfg_raw : cfg_q;

  cis_tg_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(enable),
    .div   (cfg_q.div),
    .line  (cfg_q.line),
    .run_q (run_q),
    .ph_q  (ph_q),
    .pix_q (pix_q),
    .run_n (run_n),
    .ph_n  (ph_n),
    .pix_n (pix_n),
    .start (start),
    .wrap  (wrap)
  );

  cis_tg_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_n      (run_n),
    .ph_n       (ph_n),
    .pix_n      (pix_n),
    .hi_use     (cfg_use.hi),
    .pos_use    (cfg_use.pos),
    .npix_use   (cfg_use.npix),
    .run_q      (run_q),
    .wrap       (wrap),
    .pix_q      (pix_q),
    .npix_q     (cfg_q.npix),
    .eos_in     (eos_in),
    .shift_clk  (shift_clk),
    .cap_reset  (cap_reset),
    .start_pulse(start_pulse),
    .adc_strobe (adc_strobe),
    .line_done  (line_done),
    .eos_error  (eos_error)
  );

  // R5
  line_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cfg_q.line >= cfg_q.npix));
  // R6
  short_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_line |=> short_line);
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start) |=> $stable(cfg_q));
endmodule

// File: tb/cis_timing_gen_bench.sv
module cis_timing_gen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, enable, duty_half, eos_in;
  logic [15:0] div_cfg, line_cfg;
  logic [4:0]  die_cfg;
  logic [7:0]  settle_cfg;
  logic shift_clk, start_pulse, cap_reset, adc_strobe, line_done, short_line, eos_error;

  cis_timing_gen u_cis_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_cfg(div_cfg), .duty_half(duty_half),
    .line_cfg(line_cfg), .die_cfg(die_cfg), .settle_cfg(settle_cfg), .eos_in(eos_in),
    .shift_clk(shift_clk), .start_pulse(start_pulse), .cap_reset(cap_reset),
    .adc_strobe(adc_strobe), .line_done(line_done), .short_line(short_line), .eos_error(eos_error)
  );

  int checks = 0;
  int errors = 0;
  int e_sh, e_rsw, e_st, e_stb, e_ld, e_err;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    int v;
    v = {shift_clk, start_pulse, cap_reset, adc_strobe, line_done};
    check(v == 0, req, "drive outputs", v, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; eos_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Runs the block with one configuration and compares every sample with the model.
  task automatic run_cmp(input int div, input int duty, input int line, input int dies,
                         input int settle, input bit eos_ok, input bit scramble, input int nsamp);
    int dv, hi, de, np, ln, pos;
    dv  = (div < 4) ? 4 : div;
    hi  = duty ? dv / 2 : dv / 4;
    de  = (dies == 0) ? 1 : ((dies > 16) ? 16 : dies);
    np  = de * 96;
    ln  = (line < np) ? np : line;
    pos = (hi + settle > dv - 1) ? dv - 1 : hi + settle;
    e_sh = 0; e_rsw = 0; e_st = 0; e_stb = 0; e_ld = 0; e_err = 0;
    div_cfg = 16'(div); duty_half = duty[0]; line_cfg = 16'(line);
    die_cfg = 5'(dies); settle_cfg = 8'(settle); eos_in = 1'b0;
    enable = 1'b1;
    for (int s = 0; s < nsamp; s++) begin
      int p, ph, pix;
      bit x_sh, x_st, x_stb, x_ld, x_err;
      @(negedge clk);
      p = s / dv; ph = s % dv; pix = p % ln;
      x_sh  = (ph < hi);
      x_st  = (pix == 0);
      x_stb = (ph == pos) && (pix < np);
      x_ld  = (ph == 0) && (p >= 1) && (((p - 1) % ln) == np - 1);
      x_err = !eos_ok && (s >= np * dv);
      if (shift_clk   !== x_sh)  e_sh++;
      if (cap_reset   !== x_sh)  e_rsw++;
      if (start_pulse !== x_st)  e_st++;
      if (adc_strobe  !== x_stb) e_stb++;
      if (line_done   !== x_ld)  e_ld++;
      if (eos_error   !== x_err) e_err++;
      eos_in = eos_ok && (pix == np - 1);
      if (scramble && s == 5) begin
        div_cfg = 16'd5; duty_half = ~duty_half; line_cfg = 16'd400;
        die_cfg = 5'd2; settle_cfg = 8'd0;
      end
    end
  endtask

  task automatic report(input string tag);
    check(e_sh  == 0, "R2 R3", {tag, " shift_clk mismatches"}, e_sh, 0);
    check(e_rsw == 0, "R3",    {tag, " cap_reset mismatches"}, e_rsw, 0);
    check(e_st  == 0, "R4 R5", {tag, " start_pulse mismatches"}, e_st, 0);
    check(e_stb == 0, "R7",    {tag, " adc_strobe mismatches"}, e_stb, 0);
    check(e_ld  == 0, "R8",    {tag, " line_done mismatches"}, e_ld, 0);
    check(e_err == 0, "R9",    {tag, " eos_error mismatches"}, e_err, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check_idle("R1 in reset");
    check(short_line == 1'b0 && eos_error == 1'b0, "R1", "flags in reset",
          {short_line, eos_error}, 0);
    rst_n = 1'b1; div_cfg = 16'd8; line_cfg = 16'd0; die_cfg = 5'd1; settle_cfg = 8'd1;
    duty_half = 1'b0;
    repeat (5) @(negedge clk);
    check_idle("R1 enable low");
  endtask

  task automatic t_quarter();
    do_reset(); rst_n = 1'b1; @(negedge clk);
    run_cmp(8, 0, 0, 1, 1, 1'b1, 1'b0, 2 * 96 * 8 + 20);
    report("quarter");
    check(short_line == 1'b1, "R6", "short request flagged", short_line, 1);
  endtask

  task automatic t_half();
    do_reset(); rst_n = 1'b1; @(negedge clk);
    run_cmp(10, 1, 250, 2, 9, 1'b1, 1'b0, 250 * 10 + 40);
    report("half");
    check(short_line == 1'b0, "R6", "long request not flagged", short_line, 0);
  endtask

  task automatic t_clamp();
    do_reset(); rst_n = 1'b1; @(negedge clk);
    run_cmp(2, 0, 100, 0, 0, 1'b1, 1'b0, 100 * 4 * 2 + 12);
    report("clamp R2 R5");
  endtask

  task automatic t_eos_missing();
    do_reset(); rst_n = 1'b1; @(negedge clk);
    run_cmp(4, 0, 96, 1, 0, 1'b0, 1'b0, 96 * 4 * 2 + 8);
    report("missing eos");
    check(eos_error == 1'b1, "R9", "error held", eos_error, 1);
  endtask

  task automatic t_freeze();
    do_reset(); rst_n = 1'b1; @(negedge clk);
    run_cmp(6, 1, 120, 1, 2, 1'b1, 1'b1, 120 * 6 + 30);
    report("frozen cfg R10");
    enable = 1'b0;
    @(negedge clk);
    check_idle("R1 after disable");
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; eos_in = 1'b0; duty_half = 1'b0;
    div_cfg = '0; line_cfg = '0; die_cfg = '0; settle_cfg = '0;
    t_reset();
    t_quarter();
    t_half();
    t_clamp();
    t_eos_missing();
    t_freeze();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule